// File: doc/BRIEF.md
# Byte Store Execute Stage with Translation Fault Handling

This block runs one store-byte operation with an immediate offset. The address is a base register value plus an immediate. By default the immediate is a 16-bit field, sign-extended. When a prefix instruction came just before, its upper bits stand in for the sign extension. The low byte of the source register goes out on a byte-lane write port, copied onto every lane. A single-bit byte enable picks the lane in big-endian order.

The block holds the machine mode bits (user mode, virtual mode and the saved copy of each) and the exception status fields (cause code, store indicator, zone indicator). Translation-miss and protection-fault flags come from an outside lookup, together with the operation. While virtual mode is on, these flags can turn the store into an exception. An exception suppresses the write, records its cause, saves the mode bits and clears them. A load strobe sets the user and virtual mode bits.

The parameter `AREA_OPT` sets the latency. With the value 1, the address stage is registered and results appear two cycles after the operation. With any other value they appear one cycle after it.

Top module: `sb_exec`

## Requirements
- R1: With `pfx_valid`=0 the write address equals `base_val` plus `imm_val` sign-extended to `DW` bits, modulo 2^DW.
- R2: With `pfx_valid`=1 the write address equals `base_val` plus the concatenation {`pfx_hi`, `imm_val`}.
- R3: A write drives `wr_data` with `src_val[7:0]` copied on all lanes. `wr_be` has exactly one bit set: address[1:0]=00 gives 4'b1000, 01 gives 4'b0100, 10 gives 4'b0010 and 11 gives 4'b0001.
- R4: While `msr_vm`=0, an operation always produces a write and never an exception, whatever `xlat_miss`, `prot_fault` and `prot_noacc` are.
- R5: While `msr_vm`=1 and `xlat_miss`=1, the operation produces an exception with cause 5'b10010 and `esr_store`=1, and no write. This holds whatever the protection flags are, and `esr_zone` keeps its previous value.
- R6: While `msr_vm`=1, `xlat_miss`=0 and `prot_fault`=1, the operation produces an exception with cause 5'b10000 and `esr_store`=1, and no write. `esr_zone` becomes 1 only when `prot_noacc`=1 and `msr_um`=1; otherwise it becomes 0.
- R7: On either exception, `msr_ums` takes the prior `msr_um` and `msr_vms` takes the prior `msr_vm`, and then `msr_um` and `msr_vm` both become 0.
- R8: `wr_valid` or `exc_valid` rises one cycle after `op_valid` when `AREA_OPT`≠1 and two cycles after it when `AREA_OPT`=1. Operations on consecutive cycles come out on consecutive cycles, in order.
- R9: Each operation gives exactly one single-cycle pulse, on either `wr_valid` or `exc_valid`; the two are never high together.
- R10: After reset every output is 0.
- R11: A `mode_load` pulse makes `msr_um` and `msr_vm` equal `mode_um_in` and `mode_vm_in` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A store operation is presented this cycle |
| base_val | input | DW | Base register value |
| imm_val | input | IMM_W | Immediate field |
| pfx_valid | input | 1 | A prefix instruction supplies the upper immediate bits |
| pfx_hi | input | DW-IMM_W | Upper immediate bits from the prefix |
| src_val | input | DW | Source register; only bits 7:0 are stored |
| xlat_miss | input | 1 | Lookup found no translation for the address |
| prot_fault | input | 1 | Lookup found the access forbidden |
| prot_noacc | input | 1 | Forbidden because the zone allows no access (else read-only) |
| mode_load | input | 1 | Load the user and virtual mode bits |
| mode_um_in | input | 1 | User mode value to load |
| mode_vm_in | input | 1 | Virtual mode value to load |
| wr_valid | output | 1 | Byte write pulse |
| wr_addr | output | DW | Effective address of the write |
| wr_data | output | DW | Stored byte copied on all lanes |
| wr_be | output | DW/8 | Byte enable, big-endian lane order |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause code |
| esr_store | output | 1 | Exception came from a store |
| esr_zone | output | 1 | Storage exception came from a no-access zone |
| msr_um | output | 1 | User mode |
| msr_vm | output | 1 | Virtual mode |
| msr_ums | output | 1 | Saved user mode |
| msr_vms | output | 1 | Saved virtual mode |

## Verification
The checker watches every cycle for the following. A write and an exception never coincide. An exception always follows a cycle with virtual mode on, and it leaves both mode bits cleared, the saved user bit equal to the prior user bit and the saved virtual bit set. The cause is one of the two codes, with the store indicator set. A miss leaves the zone bit unchanged, and a set zone bit implies saved user mode. A write enables exactly one lane. Only the bench can show the following: the exact sum for signed and prefixed immediates, the lane picked by each address, which flag wins when both are set, the pipelined latency of each configuration and the effect of a mode load.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_XLAT_MISS = 5'b10010;
    localparam logic [CAUSE_W-1:0] CAUSE_STORAGE   = 5'b10000;

    typedef struct packed {
        logic               um;
        logic               vm;
        logic               ums;
        logic               vms;
        logic [CAUSE_W-1:0] cause;
        logic               store;
        logic               zone;
    } mstat_t;
endpackage

// File: rtl/sb_agen.sv
module sb_agen #(
    parameter int DW    = 32,
    parameter int IMM_W = 16
) (
    input  logic [DW-1:0]       base_val,
    input  logic [IMM_W-1:0]    imm_val,
    input  logic                pfx_valid,
    input  logic [DW-IMM_W-1:0] pfx_hi,
    output logic [DW-1:0]       ea
);
    localparam int PFX_W = DW - IMM_W;

    logic [DW-1:0] imm_ext;

    always_comb begin
        if (pfx_valid) begin
            imm_ext = {pfx_hi, imm_val};
        end else begin
            imm_ext = {{PFX_W{imm_val[IMM_W-1]}}, imm_val};
        end
        ea = base_val + imm_ext;
    end
endmodule

// File: rtl/sb_fault.sv
module sb_fault
    import sb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LB    = 2
) (
    input  logic             valid,
    input  logic [LB-1:0]    lane,
    input  logic             miss,
    input  logic             prot,
    input  logic             noacc,
    input  mstat_t           stat_q,
    output logic             wr_v,
    output logic [LANES-1:0] be,
    output logic             exc_v,
    output mstat_t           stat_d
);
    always_comb begin
        stat_d = stat_q;
        wr_v   = 1'b0;
        exc_v  = 1'b0;
        if (valid) begin
            if (stat_q.vm && miss) begin
                exc_v        = 1'b1;
                stat_d.cause = CAUSE_XLAT_MISS;
                stat_d.store = 1'b1;
            end else if (stat_q.vm && prot) begin
                exc_v        = 1'b1;
                stat_d.cause = CAUSE_STORAGE;
                stat_d.store = 1'b1;
                stat_d.zone  = noacc & stat_q.um;
            end else begin
                wr_v = 1'b1;
            end
            if (exc_v) begin
                stat_d.ums = stat_q.um;
                stat_d.vms = stat_q.vm;
                stat_d.um  = 1'b0;
                stat_d.vm  = 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            be[i] = (lane == LB'(LANES - 1 - i));
        end
    end
endmodule

// File: rtl/sb_exec.sv
module sb_exec
    import sb_pkg::*;
#(
    parameter int DW       = 32,
    parameter int IMM_W    = 16,
    parameter int AREA_OPT = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [DW-1:0]       base_val,
    input  logic [IMM_W-1:0]    imm_val,
    input  logic                pfx_valid,
    input  logic [DW-IMM_W-1:0] pfx_hi,
    input  logic [DW-1:0]       src_val,
    input  logic                xlat_miss,
    input  logic                prot_fault,
    input  logic                prot_noacc,
    input  logic                mode_load,
    input  logic                mode_um_in,
    input  logic                mode_vm_in,
    output logic                wr_valid,
    output logic [DW-1:0]       wr_addr,
    output logic [DW-1:0]       wr_data,
    output logic [DW/8-1:0]     wr_be,
    output logic                exc_valid,
    output logic [CAUSE_W-1:0]  exc_cause,
    output logic                esr_store,
    output logic                esr_zone,
    output logic                msr_um,
    output logic                msr_vm,
    output logic                msr_ums,
    output logic                msr_vms
);
    localparam int LANES = DW / 8;
    localparam int LB    = $clog2(LANES);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] addr;
        logic [7:0]    b;
        logic          miss;
        logic          prot;
        logic          noacc;
    } stage_t;

    typedef struct packed {
        logic             wr_v;
        logic [DW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [LANES-1:0] be;
        logic             exc_v;
        mstat_t           st;
    } state_t;

    logic [DW-1:0]    ea;
    stage_t           stg_d;
    stage_t           stg_use;
    state_t           reg_d;
    state_t           reg_q;
    logic             f_wr;
    logic             f_exc;
    logic [LANES-1:0] f_be;
    mstat_t           f_stat;
    logic             unused_src;

    assign unused_src = ^src_val[DW-1:8];

    sb_agen #(.DW(DW), .IMM_W(IMM_W)) u_agen (
        .base_val (base_val),
        .imm_val  (imm_val),
        .pfx_valid(pfx_valid),
        .pfx_hi   (pfx_hi),
        .ea       (ea)
    );

    always_comb begin
        stg_d.v     = op_valid;
        stg_d.addr  = ea;
        stg_d.b     = src_val[7:0];
        stg_d.miss  = xlat_miss;
        stg_d.prot  = prot_fault;
        stg_d.noacc = prot_noacc;
    end

    generate
        if (AREA_OPT == 1) begin : g_two_cycle
            stage_t stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= stg_d;
                end
            end
            assign stg_use = stg_q;
        end else begin : g_one_cycle
            assign stg_use = stg_d;
        end
    endgenerate

    sb_fault #(.LANES(LANES), .LB(LB)) u_fault (
        .valid (stg_use.v),
        .lane  (stg_use.addr[LB-1:0]),
        .miss  (stg_use.miss),
        .prot  (stg_use.prot),
        .noacc (stg_use.noacc),
        .stat_q(reg_q.st),
        .wr_v  (f_wr),
        .be    (f_be),
        .exc_v (f_exc),
        .stat_d(f_stat)
    );

    always_comb begin
        reg_d       = reg_q;
        reg_d.wr_v  = f_wr;
        reg_d.exc_v = f_exc;
        reg_d.st    = f_stat;
        if (f_wr) begin
            reg_d.addr = stg_use.addr;
            reg_d.data = {LANES{stg_use.b}};
            reg_d.be   = f_be;
        end
        if (!f_exc && mode_load) begin
            reg_d.st.um = mode_um_in;
            reg_d.st.vm = mode_vm_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign wr_valid  = reg_q.wr_v;
    assign wr_addr   = reg_q.addr;
    assign wr_data   = reg_q.data;
    assign wr_be     = reg_q.be;
    assign exc_valid = reg_q.exc_v;
    assign exc_cause = reg_q.st.cause;
    assign esr_store = reg_q.st.store;
    assign esr_zone  = reg_q.st.zone;
    assign msr_um    = reg_q.st.um;
    assign msr_vm    = reg_q.st.vm;
    assign msr_ums   = reg_q.st.ums;
    assign msr_vms   = reg_q.st.vms;
endmodule

// File: rtl/sb_exec_chk.sv
module sb_exec_chk
    import sb_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [LANES-1:0]   wr_be,
    input logic               exc_valid,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic               esr_store,
    input logic               esr_zone,
    input logic               msr_um,
    input logic               msr_vm,
    input logic               msr_ums,
    input logic               msr_vms
);
    assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && exc_valid));

    assert_vm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(msr_vm));

    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!msr_um && !msr_vm && msr_vms));

    assert_save_um_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (msr_ums == $past(msr_um)));

    assert_cause_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (esr_store &&
                       (exc_cause == CAUSE_XLAT_MISS || exc_cause == CAUSE_STORAGE)));

    assert_zone_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_XLAT_MISS) |-> (esr_zone == $past(esr_zone)));

    assert_zone_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_STORAGE && esr_zone) |-> msr_ums);

    assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(wr_be) == 1));
endmodule

bind sb_exec sb_exec_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_be    (wr_be),
    .exc_valid(exc_valid),
    .exc_cause(exc_cause),
    .esr_store(esr_store),
    .esr_zone (esr_zone),
    .msr_um   (msr_um),
    .msr_vm   (msr_vm),
    .msr_ums  (msr_ums),
    .msr_vms  (msr_vms)
);

// File: tb/sim_sb_exec.sv
`timescale 1ns/1ps
module sim_sb_exec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        op_valid = 0, pfx_valid = 0, xlat_miss = 0, prot_fault = 0, prot_noacc = 0;
    logic        mode_load = 0, mode_um_in = 0, mode_vm_in = 0;
    logic [31:0] base_val = 0, src_val = 0;
    logic [15:0] imm_val = 0, pfx_hi = 0;

    logic        wv0, ev0, s0, z0, um0, vm0, ums0, vms0;
    logic        wv1, ev1, s1, z1, um1, vm1, ums1, vms1;
    logic [31:0] wa0, wd0, wa1, wd1;
    logic [3:0]  be0, be1;
    logic [4:0]  c0, c1;

    sb_exec #(.AREA_OPT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .base_val(base_val), .imm_val(imm_val),
        .pfx_valid(pfx_valid), .pfx_hi(pfx_hi), .src_val(src_val), .xlat_miss(xlat_miss),
        .prot_fault(prot_fault), .prot_noacc(prot_noacc), .mode_load(mode_load),
        .mode_um_in(mode_um_in), .mode_vm_in(mode_vm_in), .wr_valid(wv0), .wr_addr(wa0),
        .wr_data(wd0), .wr_be(be0), .exc_valid(ev0), .exc_cause(c0), .esr_store(s0),
        .esr_zone(z0), .msr_um(um0), .msr_vm(vm0), .msr_ums(ums0), .msr_vms(vms0));

    sb_exec #(.AREA_OPT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .base_val(base_val), .imm_val(imm_val),
        .pfx_valid(pfx_valid), .pfx_hi(pfx_hi), .src_val(src_val), .xlat_miss(xlat_miss),
        .prot_fault(prot_fault), .prot_noacc(prot_noacc), .mode_load(mode_load),
        .mode_um_in(mode_um_in), .mode_vm_in(mode_vm_in), .wr_valid(wv1), .wr_addr(wa1),
        .wr_data(wd1), .wr_be(be1), .exc_valid(ev1), .exc_cause(c1), .esr_store(s1),
        .esr_zone(z1), .msr_um(um1), .msr_vm(vm1), .msr_ums(ums1), .msr_vms(vms1));

    int total = 0, failed = 0;
    bit done = 0;

    // model state
    logic m_um = 0, m_vm = 0, m_ums = 0, m_vms = 0, m_s = 0, m_z = 0;
    logic [4:0] m_c = 0;
    logic e_wv, e_ev;
    logic [31:0] e_wa, e_wd;
    logic [3:0] e_be;
    string t_addr, t_exc, t_kind;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ea(logic [31:0] b, logic [15:0] i, logic p, logic [15:0] h);
        return b + (p ? {h, i} : {{16{i[15]}}, i});
    endfunction

    function automatic logic [3:0] model_be(logic [31:0] a);
        return 4'b1000 >> a[1:0];
    endfunction

    task automatic cmp(string inst, logic wv, logic [31:0] wa, logic [31:0] wd, logic [3:0] be,
                       logic ev, logic [4:0] c, logic s, logic z,
                       logic um, logic vm, logic ums, logic vms);
        chk(t_kind, {inst, " wr_valid"}, 32'(wv), 32'(e_wv));
        chk(t_kind, {inst, " exc_valid"}, 32'(ev), 32'(e_ev));
        if (e_wv) begin
            chk(t_addr, {inst, " wr_addr"}, wa, e_wa);
            chk("R3", {inst, " wr_data"}, wd, e_wd);
            chk("R3", {inst, " wr_be"}, 32'(be), 32'(e_be));
        end
        if (e_ev) begin
            chk(t_exc, {inst, " cause"}, 32'(c), 32'(m_c));
            chk(t_exc, {inst, " store"}, 32'(s), 32'(m_s));
            chk(t_exc, {inst, " zone"}, 32'(z), 32'(m_z));
        end
        chk("R7", {inst, " mode bits"}, 32'({um, vm, ums, vms}), 32'({m_um, m_vm, m_ums, m_vms}));
    endtask

    task automatic set_mode(logic u, logic v);
        @(negedge clk);
        mode_load = 1; mode_um_in = u; mode_vm_in = v;
        @(negedge clk);
        mode_load = 0;
        m_um = u; m_vm = v;
        chk("R11", "u0 mode", 32'({um0, vm0}), 32'({u, v}));
        chk("R11", "u1 mode", 32'({um1, vm1}), 32'({u, v}));
    endtask

    task automatic predict(logic [31:0] b, logic [15:0] i, logic p, logic [15:0] h,
                           logic [31:0] sv, logic mi, logic pr, logic na);
        e_wa = model_ea(b, i, p, h);
        e_be = model_be(e_wa);
        e_wd = {4{sv[7:0]}};
        t_addr = p ? "R2" : "R1";
        t_kind = (!m_vm && (mi || pr)) ? "R4" : "R9";
        e_wv = 0; e_ev = 0;
        if (m_vm && mi) begin
            e_ev = 1; m_c = 5'b10010; m_s = 1; t_exc = "R5";
        end else if (m_vm && pr) begin
            e_ev = 1; m_c = 5'b10000; m_s = 1; m_z = na & m_um; t_exc = "R6";
        end else begin
            e_wv = 1;
        end
        if (e_ev) begin
            m_ums = m_um; m_vms = m_vm; m_um = 0; m_vm = 0;
        end
    endtask

    task automatic do_op(logic [31:0] b, logic [15:0] i, logic p, logic [15:0] h,
                         logic [31:0] sv, logic mi, logic pr, logic na);
        @(negedge clk);
        op_valid = 1; base_val = b; imm_val = i; pfx_valid = p; pfx_hi = h; src_val = sv;
        xlat_miss = mi; prot_fault = pr; prot_noacc = na;
        predict(b, i, p, h, sv, mi, pr, na);
        @(negedge clk);
        op_valid = 0;
        cmp("u0", wv0, wa0, wd0, be0, ev0, c0, s0, z0, um0, vm0, ums0, vms0);
        chk("R8", "u1 early valid", 32'({wv1, ev1}), 32'(0));
        @(negedge clk);
        cmp("u1", wv1, wa1, wd1, be1, ev1, c1, s1, z1, um1, vm1, ums1, vms1);
        chk("R9", "u0 pulse width", 32'({wv0, ev0}), 32'(0));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "u0 outputs", {wv0, ev0, c0, s0, z0, um0, vm0, ums0, vms0, be0} , 32'(0));
        chk("R10", "u0 addr/data", wa0 | wd0, 32'(0));
        chk("R10", "u1 outputs", {wv1, ev1, c1, s1, z1, um1, vm1, ums1, vms1, be1}, 32'(0));

        // R1 sign extension corners, R3 all lanes
        do_op(32'h0000_0000, 16'h8000, 0, 16'h0, 32'h1234_56A5, 0, 0, 0);
        do_op(32'h1000_0001, 16'h7FFF, 0, 16'h0, 32'h0000_003C, 0, 0, 0);
        do_op(32'h0000_0002, 16'hFFFF, 0, 16'h0, 32'hFFFF_FF11, 0, 0, 0);
        do_op(32'hFFFF_FFFF, 16'h0004, 0, 16'h0, 32'h0000_0099, 0, 0, 0);
        // R2 prefix
        do_op(32'h0000_0010, 16'h8001, 1, 16'h1234, 32'h0000_0077, 0, 0, 0);
        // R4 flags ignored with virtual mode off
        do_op(32'h0000_0100, 16'h0003, 0, 16'h0, 32'h0000_0042, 1, 1, 1);
        // R5 miss wins over protection
        set_mode(1, 1);
        do_op(32'h0000_0200, 16'h0000, 0, 16'h0, 32'h0000_0001, 1, 1, 1);
        // R6 no-access in user mode -> zone 1
        set_mode(1, 1);
        do_op(32'h0000_0300, 16'h0000, 0, 16'h0, 32'h0000_0002, 0, 1, 1);
        // R5 zone keeps 1 across a miss
        set_mode(0, 1);
        do_op(32'h0000_0400, 16'h0000, 0, 16'h0, 32'h0000_0003, 1, 0, 0);
        // R6 no-access flag in kernel mode -> zone 0
        set_mode(0, 1);
        do_op(32'h0000_0500, 16'h0000, 0, 16'h0, 32'h0000_0004, 0, 1, 1);
        // R6 protection but no fault in vm: write goes out
        set_mode(1, 1);
        do_op(32'h0000_0600, 16'h0001, 0, 16'h0, 32'h0000_0005, 0, 0, 1);

        // R8 back-to-back in order
        set_mode(0, 0);
        @(negedge clk);
        op_valid = 1; base_val = 32'h0000_1000; imm_val = 16'h0; pfx_valid = 0; src_val = 32'hAA;
        xlat_miss = 0; prot_fault = 0;
        @(negedge clk);
        base_val = 32'h0000_2001; src_val = 32'hBB;
        chk("R8", "u0 first", wa0, 32'h0000_1000);
        chk("R8", "u1 not yet", 32'(wv1), 32'(0));
        @(negedge clk);
        op_valid = 0;
        chk("R8", "u0 second", wa0, 32'h0000_2001);
        chk("R8", "u1 first", {wv1, wa1[30:0]}, {1'b1, 31'h0000_1000});
        @(negedge clk);
        chk("R8", "u1 second", {wv1, wa1[30:0]}, {1'b1, 31'h0000_2001});
        chk("R8", "u0 idle", 32'(wv0), 32'(0));

        // random mix
        for (int n = 0; n < 400; n++) begin
            if (n % 3 == 0) set_mode(1'($urandom), ($urandom % 4) != 0);
            do_op($urandom, 16'($urandom), ($urandom % 4) == 0, 16'($urandom), $urandom,
                  ($urandom % 4) == 0, ($urandom % 3) == 0, 1'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule